// File: doc/BRIEF.md
# Two-Cycle Byte Memory Port

This block sits between a microcoded 8-bit datapath and one byte-wide memory of 65536 locations that holds both code and data. The datapath feeds it two decoded microinstruction fields every cycle: the ALU destination code, with the ALU result byte, and a memory destination code. From these the block keeps a high address byte, a low address byte, a store-data byte, a fetched-data byte and an instruction byte. It drives the 16-bit address, the store data and a write enable onto the memory bus.

No separate strobe starts an access. Writing the low address byte with the read destination code or the write destination code starts one. The access then occupies the following two cycles. The microprogram loads the high address byte first, and for a store it places the data byte before it starts the access. The byte on the read bus is captured when the microinstruction names a memory destination. One code can load up to three registers from the same bus byte, so an opcode fetch can fill the instruction register, the data register and the low address byte in one cycle.

Top module: `byte_mem_port`

## Requirements
- R1: While `rst_n` is low, the address, store-data, fetched-data and instruction registers are zero. `busy`, `access_err` and `mem_we` are also low.
- R2: When the block is idle, ALU destination code 10 loads `alu_result` into the high address byte and code 15 loads it into the store-data byte. Both show on `mem_addr[15:8]` and `mem_wdata` after the clock edge.
- R3: When idle, ALU destination code 11 loads `alu_result` into the low address byte and starts a read. `busy` is then high for exactly the next two cycles and `mem_we` stays low.
- R4: When idle, ALU destination code 13 loads the low address byte and starts a write. `busy` is high for the next two cycles. `mem_we` is high only in the second of them. `mem_addr` and `mem_wdata` hold their values across both cycles.
- R5: Memory destination code 1 loads `mem_rdata` into `rd_data` only.
- R6: Memory destination code 2 loads `mem_rdata` into `rd_data` and into the low address byte.
- R7: Memory destination code 3 loads `mem_rdata` into `rd_data`, the low address byte and `instr`. Code 0 loads none of them.
- R8: ALU destination code 11 or 13 while `busy` is high does not change the low address byte and does not lengthen the access. It sets `access_err`, which then stays high until reset.
- R9: ALU destination codes 10 and 15 have no effect while `busy` is high.
- R10: A memory destination load into the low address byte is ignored in the first cycle of an access. In the cycle that starts an access, the ALU result wins over the bus byte for the low address byte.
- R11: ALU destination codes 0 to 9, 12 and 14 change nothing in this block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_dest | input | 4 | Decoded ALU destination code |
| alu_result | input | 8 | ALU output byte |
| mem_dest | input | 2 | Memory destination code (0 none, 1 data, 2 data and low address, 3 data, low address and instruction) |
| mem_rdata | input | 8 | Read byte from the memory bus |
| mem_addr | output | 16 | Memory address, high byte above low byte |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Write enable, one cycle per write |
| addr_hi | output | 8 | High address byte |
| addr_lo | output | 8 | Low address byte |
| rd_data | output | 8 | Last captured bus byte |
| instr | output | 8 | Instruction register |
| busy | output | 1 | Access in progress |
| access_err | output | 1 | Sticky flag for a start while busy |

## Verification
A wrong phase count shows up at once on `busy`. The fault also reaches `mem_we` within two cycles, as a write enable missing from the second cycle or placed in the wrong one. An address or store-data byte that was loaded wrongly, or changed in the middle of an access, shows on `mem_addr` or `mem_wdata` in the cycle after the edge. It also spreads later, because a store lands at the wrong location and a fetch then returns an unexpected byte. A capture aimed at the wrong register shows on `rd_data`, `addr_lo` or `instr` one cycle after the microinstruction. A missed or spurious error shows on `access_err` and stays visible from then on.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

  localparam logic [3:0] DST_ADDR_HI = 4'd10;
  localparam logic [3:0] DST_RD_LO   = 4'd11;
  localparam logic [3:0] DST_WR_LO   = 4'd13;
  localparam logic [3:0] DST_STORE   = 4'd15;

  typedef enum logic [1:0] {
    MD_NONE    = 2'd0,
    MD_DATA    = 2'd1,
    MD_DATA_LO = 2'd2,
    MD_ALL     = 2'd3
  } mdest_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/bmp_seq.sv
module bmp_seq
  import bmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_rd,
  input  logic start_wr,
  output logic busy,
  output logic first_phase,
  output logic accept,
  output logic mem_we,
  output logic access_err
);

  phase_e ph_q, ph_d;
  logic   wr_q, wr_d;
  logic   err_q, err_d;
  logic   start;

  assign start       = start_rd | start_wr;
  assign busy        = (ph_q != PH_IDLE);
  assign accept      = start & ~busy;
  assign first_phase = (ph_q == PH_ADDR);
  assign mem_we      = (ph_q == PH_DATA) & wr_q;
  assign access_err  = err_q;

  always_comb begin
    ph_d  = ph_q;
    wr_d  = wr_q;
    err_d = err_q | (start & busy);
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d = PH_ADDR;
          wr_d = start_wr;
        end
      end
      PH_ADDR: ph_d = PH_DATA;
      PH_DATA: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      wr_q  <= wr_d;
      err_q <= err_d;
    end
  end

  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy); // R3

  AST_WE_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy && $past(busy)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |=> access_err); // R8

endmodule

// File: rtl/bmp_addr_regs.sv
module bmp_addr_regs
  import bmp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    alu_dest,
  input  logic [DW-1:0] alu_result,
  input  logic [DW-1:0] bus_data,
  input  mdest_e        mdest,
  input  logic          accept,
  input  logic          busy,
  input  logic          first_phase,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] addr_lo,
  output logic [DW-1:0] store_data
);

  localparam int HW = AW - DW;

  logic [HW-1:0] hi_q, hi_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [DW-1:0] st_q, st_d;
  logic          hi_en, st_en, lo_from_alu, lo_from_bus;

  always_comb begin
    hi_en       = ~busy & (alu_dest == DST_ADDR_HI);
    st_en       = ~busy & (alu_dest == DST_STORE);
    lo_from_alu = accept;
    lo_from_bus = ~accept & ~first_phase &
                  ((mdest == MD_DATA_LO) || (mdest == MD_ALL));
    hi_d = hi_en ? HW'(alu_result) : hi_q;
    st_d = st_en ? alu_result : st_q;
    if (lo_from_alu)      lo_d = alu_result;
    else if (lo_from_bus) lo_d = bus_data;
    else                  lo_d = lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      st_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      st_q <= st_d;
    end
  end

  assign addr_hi    = hi_q;
  assign addr_lo    = lo_q;
  assign store_data = st_q;

  AST_HI_HELD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_hi)); // R9

  AST_LO_HELD_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    first_phase |=> $stable(addr_lo)); // R10

endmodule

// File: rtl/bmp_capture.sv
module bmp_capture
  import bmp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mdest_e        mdest,
  input  logic [DW-1:0] bus_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] instr
);

  logic [DW-1:0] md_q, md_d;
  logic [DW-1:0] ir_q, ir_d;
  logic          md_en, ir_en;

  always_comb begin
    md_en = (mdest != MD_NONE);
    ir_en = (mdest == MD_ALL);
    md_d  = md_en ? bus_data : md_q;
    ir_d  = ir_en ? bus_data : ir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md_q <= '0;
      ir_q <= '0;
    end else begin
      md_q <= md_d;
      ir_q <= ir_d;
    end
  end

  assign rd_data = md_q;
  assign instr   = ir_q;

  AST_IR_ONLY_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(instr) |-> $past(mdest) == MD_ALL); // R7

endmodule

// File: rtl/byte_mem_port.sv
module byte_mem_port
  import bmp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    alu_dest,
  input  logic [DW-1:0] alu_result,
  input  logic [1:0]    mem_dest,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] addr_lo,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] instr,
  output logic          busy,
  output logic          access_err
);

  mdest_e mdest;
  logic   start_rd, start_wr, accept, first_phase;

  assign mdest    = mdest_e'(mem_dest);
  assign start_rd = (alu_dest == DST_RD_LO);
  assign start_wr = (alu_dest == DST_WR_LO);

  bmp_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_rd    (start_rd),
    .start_wr    (start_wr),
    .busy        (busy),
    .first_phase (first_phase),
    .accept      (accept),
    .mem_we      (mem_we),
    .access_err  (access_err)
  );

  bmp_addr_regs #(.DW(DW), .AW(AW)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_dest    (alu_dest),
    .alu_result  (alu_result),
    .bus_data    (mem_rdata),
    .mdest       (mdest),
    .accept      (accept),
    .busy        (busy),
    .first_phase (first_phase),
    .addr_hi     (addr_hi),
    .addr_lo     (addr_lo),
    .store_data  (mem_wdata)
  );

  bmp_capture #(.DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdest    (mdest),
    .bus_data (mem_rdata),
    .rd_data  (rd_data),
    .instr    (instr)
  );

  assign mem_addr = {addr_hi, addr_lo};

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_addr) && $stable(mem_wdata)); // R4

endmodule

// File: tb/byte_mem_port_bench.sv
module byte_mem_port_bench;

  logic        clk;
  logic        rst_n;
  logic [3:0]  alu_dest;
  logic [7:0]  alu_result;
  logic [1:0]  mem_dest;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  addr_hi, addr_lo, rd_data, instr;
  logic        busy, access_err;

  byte_mem_port u_byte_mem_port (
    .clk(clk), .rst_n(rst_n), .alu_dest(alu_dest), .alu_result(alu_result),
    .mem_dest(mem_dest), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .addr_hi(addr_hi),
    .addr_lo(addr_lo), .rd_data(rd_data), .instr(instr), .busy(busy),
    .access_err(access_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [7:0] mem [int unsigned];

  logic [7:0] m_hi, m_lo, m_st, m_md, m_ir;
  int         m_ph;
  bit         m_wr, m_err;

  function automatic logic [7:0] rd_mem(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input string nm, input logic [15:0] got,
                     input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h at %0t", tag, nm, got, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "mem_addr", mem_addr, {m_hi, m_lo});
    chk(tag, "addr_hi", 16'(addr_hi), 16'(m_hi));
    chk(tag, "addr_lo", 16'(addr_lo), 16'(m_lo));
    chk(tag, "mem_wdata", 16'(mem_wdata), 16'(m_st));
    chk(tag, "rd_data", 16'(rd_data), 16'(m_md));
    chk(tag, "instr", 16'(instr), 16'(m_ir));
    chk(tag, "busy", 16'(busy), 16'(m_ph != 0));
    chk(tag, "mem_we", 16'(mem_we), 16'(m_ph == 2 && m_wr));
    chk(tag, "access_err", 16'(access_err), 16'(m_err));
  endtask

  // One clock: drive at the falling edge, model at the rising edge, compare after.
  task automatic step(input logic [3:0] d, input logic [7:0] r,
                      input logic [1:0] m, input string tag);
    logic [7:0]  bus;
    logic        pre_we;
    logic [15:0] pre_a;
    logic [7:0]  pre_wd;
    bit          start, bsy;
    alu_dest   = d;
    alu_result = r;
    mem_dest   = m;
    mem_rdata  = rd_mem(mem_addr);
    pre_we     = mem_we;
    pre_a      = mem_addr;
    pre_wd     = mem_wdata;
    bus        = rd_mem({m_hi, m_lo});
    @(posedge clk);
    if (pre_we) mem[int'(pre_a)] = pre_wd;
    start = (d == 4'd11) || (d == 4'd13);
    bsy   = (m_ph != 0);
    if (!bsy && d == 4'd10) m_hi = r;
    if (!bsy && d == 4'd15) m_st = r;
    if (m != 2'd0) m_md = bus;
    if (m == 2'd3) m_ir = bus;
    if (start && !bsy) m_lo = r;
    else if (m >= 2'd2 && m_ph != 1) m_lo = bus;
    if (start && bsy) m_err = 1;
    case (m_ph)
      0: if (start) begin m_ph = 1; m_wr = (d == 4'd13); end
      1: m_ph = 2;
      default: m_ph = 0;
    endcase
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; alu_dest = 0; alu_result = 0; mem_dest = 0; mem_rdata = 0;
    m_hi = 0; m_lo = 0; m_st = 0; m_md = 0; m_ir = 0; m_ph = 0; m_wr = 0; m_err = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    step(4'd10, 8'h12, 2'd0, "R2");
    step(4'd15, 8'hA5, 2'd0, "R2");
    step(4'd13, 8'h34, 2'd0, "R4");
    step(4'd0,  8'h00, 2'd0, "R4");
    step(4'd0,  8'h00, 2'd0, "R4");
    step(4'd0,  8'h00, 2'd0, "R4");
    step(4'd11, 8'h34, 2'd0, "R3");
    step(4'd0,  8'h00, 2'd0, "R3");
    step(4'd0,  8'h00, 2'd1, "R5");
    step(4'd10, 8'h20, 2'd0, "R2");
    step(4'd11, 8'h07, 2'd0, "R3");
    step(4'd0,  8'h00, 2'd0, "R3");
    step(4'd0,  8'h00, 2'd2, "R6");
    step(4'd11, 8'h40, 2'd0, "R3");
    step(4'd0,  8'h00, 2'd0, "R3");
    step(4'd0,  8'h00, 2'd3, "R7");
    step(4'd0,  8'h00, 2'd0, "R7");

    step(4'd15, 8'h5E, 2'd0, "R2");
    step(4'd13, 8'h99, 2'd0, "R4");
    step(4'd11, 8'h11, 2'd0, "R8");
    step(4'd13, 8'h22, 2'd0, "R8");
    step(4'd0,  8'h00, 2'd0, "R8");
    step(4'd0,  8'h00, 2'd0, "R8");

    step(4'd11, 8'h50, 2'd0, "R3");
    step(4'd10, 8'h77, 2'd0, "R9");
    step(4'd15, 8'h66, 2'd0, "R9");
    step(4'd0,  8'h00, 2'd0, "R9");
    step(4'd11, 8'h60, 2'd0, "R3");
    step(4'd0,  8'h00, 2'd2, "R10");
    step(4'd0,  8'h00, 2'd0, "R10");
    step(4'd11, 8'h70, 2'd3, "R10");
    step(4'd0,  8'h00, 2'd0, "R10");
    step(4'd0,  8'h00, 2'd0, "R10");

    for (int c = 0; c < 16; c++) begin
      if (c == 10 || c == 11 || c == 13 || c == 15) continue;
      step(4'(c), 8'(8'hC3 ^ c), 2'd0, "R11");
    end

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] d;
      logic [1:0] m;
      d = 4'($urandom_range(0, 15));
      m = 2'($urandom_range(0, 3));
      step(d, 8'($urandom), m, "MIX");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule